// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Controller

This block sits after an external dual-modulus prescaler and counts the prescaler's output edges. It keeps a main count of N edges per division cycle and a second, shorter swallow count of A edges. For the first A edges of every division cycle it drives the modulus-control output low. For the remaining N−A edges it drives that output high. Once per division cycle it emits a single-period strobe that marks the divided frequency, and a phase detector downstream can use that strobe.

The block is clocked by the prescaler output itself. The two programming words are read only on the edge that starts a new division cycle, so software or switches may change them at any time without corrupting the cycle in progress. The strobe is a bare event and the block has no valid/ready handshake. A consumer cannot apply back-pressure, so a consumer that needs it must register the strobe on its own side. An A value larger than N is clamped to N. An N value of zero is run as one.

Top module: `pswallow_ctrl`

## Requirements
- R1: While `rst_n` is low, `mc` is 1 and `fv` is 0 whatever the programming inputs do. The first rising `fin` edge after release starts a division cycle.
- R2: `fv` is 1 for exactly the first `fin` period of each division cycle and 0 for the others. A cycle lasts N periods, where N is `n_val` as an unsigned number with bit 0 as the LSB.
- R3: Within a cycle `mc` is 0 (swallow) for the first A periods and 1 for the remaining N−A periods. It never returns to 0 before the next cycle starts.
- R4: With `a_val` equal to 0, `mc` is 1 for every period of the cycle.
- R5: With `a_val` greater than N, A is taken as N, so `mc` is 0 for the whole cycle.
- R6: With `n_val` equal to 0, the cycle is one period long, so `fv` stays 1. A is then clamped to 1.
- R7: `n_val` and `a_val` are sampled only on the edge that starts a cycle. Changes made during a cycle take effect from the following cycle.
- R8: The full-scale values N=1023 and A=63 (all input bits at 1) give a 1023-period cycle whose first 63 periods have `mc` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin | input | 1 | Prescaler output; all counting is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_val | input | 10 | Main divide value N (bit 0 is the LSB) |
| a_val | input | 6 | Swallow count A (bit 0 is the LSB) |
| mc | output | 1 | Modulus control: 0 while swallowing, 1 otherwise |
| fv | output | 1 | One-period strobe at the start of every division cycle |

## Verification
The embedded properties check several rules on every cycle. The strobe can follow only the terminal edge of a cycle, and the main count never reaches zero. Once the modulus control has gone high it stays high until the next reload. The swallow count never exceeds the remaining main count, which is the clamp guarantee. The exact lengths of each period need the bench's scenarios, which check the strobe position, the number of low `mc` periods, the N=0 and A>N corners, full scale, and programming changes made mid-cycle. Those scenarios compare every output period against a model.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  // Level driven on the modulus-control pin.
  typedef enum logic {
    MC_SWALLOW = 1'b0,
    MC_PASS    = 1'b1
  } mc_lvl_e;
endpackage

// File: rtl/pswallow_prog.sv
// Conditions the programming words: N of 0 is run as 1, A is widened and clamped to N.
module pswallow_prog #(
  parameter int N_W = 10,
  parameter int A_W = 6
) (
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  output logic [N_W-1:0] n_eff,
  output logic [N_W-1:0] a_eff
);
  logic [N_W-1:0] a_wide;

  generate
    if (A_W < N_W) begin : g_ext
      assign a_wide = {{(N_W-A_W){1'b0}}, a_val};
    end else begin : g_same
      assign a_wide = a_val[N_W-1:0];
    end
  endgenerate

  always_comb begin
    n_eff = (n_val == '0) ? N_W'(1) : n_val;
    a_eff = (a_wide > n_eff) ? n_eff : a_wide;
  end
endmodule

// File: rtl/pswallow_main.sv
// Main count: edges left in the current division cycle, reload at the last one.
module pswallow_main #(
  parameter int N_W = 10
) (
  input  logic           fin,
  input  logic           rst_n,
  input  logic [N_W-1:0] n_eff,
  output logic [N_W-1:0] n_rem,
  output logic           reload,
  output logic           fv
);
  assign reload = (n_rem == N_W'(1));

  always_ff @(posedge fin or negedge rst_n) begin
    if (!rst_n) begin
      n_rem <= N_W'(1);
      fv    <= 1'b0;
    end else if (reload) begin
      n_rem <= n_eff;
      fv    <= 1'b1;
    end else begin
      n_rem <= n_rem - N_W'(1);
      fv    <= 1'b0;
    end
  end

  // R2: strobe only after a terminal edge
  p_fv_after_wrap_r2: assert property (@(posedge fin) disable iff (!rst_n)
    !reload |=> !fv);

  // R2: remaining count stays live
  p_nrem_live_r2: assert property (@(posedge fin) disable iff (!rst_n)
    n_rem != '0);
endmodule

// File: rtl/pswallow_aux.sv
// Swallow count: edges left with modulus control low.
module pswallow_aux
  import pswallow_pkg::*;
#(
  parameter int N_W = 10
) (
  input  logic           fin,
  input  logic           rst_n,
  input  logic           reload,
  input  logic [N_W-1:0] a_eff,
  output logic [N_W-1:0] a_rem,
  output logic           mc
);
  mc_lvl_e lvl;

  always_ff @(posedge fin or negedge rst_n) begin
    if (!rst_n) begin
      a_rem <= '0;
    end else if (reload) begin
      a_rem <= a_eff;
    end else if (a_rem != '0) begin
      a_rem <= a_rem - N_W'(1);
    end
  end

  assign lvl = (a_rem == '0) ? MC_PASS : MC_SWALLOW;
  assign mc  = logic'(lvl);

  // R3: once passing, control stays high until the cycle ends
  p_mc_hold_r3: assert property (@(posedge fin) disable iff (!rst_n)
    (mc && !reload) |=> mc);
endmodule

// File: rtl/pswallow_ctrl.sv
// Dual-modulus pulse-swallow controller top.
module pswallow_ctrl #(
  parameter int N_W = 10,
  parameter int A_W = 6
) (
  input  logic           fin,
  input  logic           rst_n,
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  output logic           mc,
  output logic           fv
);
  logic [N_W-1:0] n_eff;
  logic [N_W-1:0] a_eff;
  logic [N_W-1:0] n_rem;
  logic [N_W-1:0] a_rem;
  logic           reload;

  pswallow_prog #(.N_W(N_W), .A_W(A_W)) u_prog (
    .n_val (n_val),
    .a_val (a_val),
    .n_eff (n_eff),
    .a_eff (a_eff)
  );

  pswallow_main #(.N_W(N_W)) u_main (
    .fin    (fin),
    .rst_n  (rst_n),
    .n_eff  (n_eff),
    .n_rem  (n_rem),
    .reload (reload),
    .fv     (fv)
  );

  pswallow_aux #(.N_W(N_W)) u_aux (
    .fin    (fin),
    .rst_n  (rst_n),
    .reload (reload),
    .a_eff  (a_eff),
    .a_rem  (a_rem),
    .mc     (mc)
  );

  // R5: swallow count never outlasts the main count
  p_swallow_bound_r5: assert property (@(posedge fin) disable iff (!rst_n)
    a_rem <= n_rem);

  // R2: a strobe means a fresh cycle of at least one edge
  p_fv_fresh_r2: assert property (@(posedge fin) disable iff (!rst_n)
    fv |-> (n_rem != '0));
endmodule

// File: tb/pswallow_ctrl_test.sv
module pswallow_ctrl_test;
  typedef struct {
    bit    fv;
    bit    mc;
    string tag;
  } exp_t;

  logic       fin = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] n_val = '0;
  logic [5:0] a_val = '0;
  logic       mc, fv;

  int   checks = 0;
  int   failures = 0;
  bit   run = 1'b0;
  exp_t sb[$];

  always #4 fin = ~fin;

  pswallow_ctrl uut (
    .fin   (fin),
    .rst_n (rst_n),
    .n_val (n_val),
    .a_val (a_val),
    .mc    (mc),
    .fv    (fv)
  );

  // Driver: called just after a negedge; the next posedge starts the cycle.
  task automatic do_cycle(input int n, input int a, input bit mid,
                          input int mn, input int ma, input string tag);
    int neff, aeff;
    n_val = n[9:0];
    a_val = a[5:0];
    neff = (n == 0) ? 1 : n;
    aeff = (a > neff) ? neff : a;
    for (int k = 0; k < neff; k++) begin
      exp_t e;
      e.fv  = (k == 0);
      e.mc  = (k >= aeff);
      e.tag = tag;
      sb.push_back(e);
    end
    @(posedge fin);
    if (mid) begin
      #2;
      n_val = mn[9:0];
      a_val = ma[5:0];
    end
    repeat (neff - 1) @(posedge fin);
    @(negedge fin);
    #1;
  endtask

  // Monitor: one expected item per fin period.
  initial begin
    forever begin
      @(negedge fin);
      if (run) begin
        checks++;
        if (sb.size() == 0) begin
          failures++;
          $display("FAIL scoreboard empty: actual fv=%0b mc=%0b expected none", fv, mc);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (fv !== e.fv || mc !== e.mc) begin
            failures++;
            $display("FAIL %s: actual fv=%0b mc=%0b expected fv=%0b mc=%0b",
                     e.tag, fv, mc, e.fv, e.mc);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset holds outputs while inputs move
    for (int i = 0; i < 4; i++) begin
      @(negedge fin);
      n_val = 10'(3 + i);
      a_val = 6'(i);
      checks++;
      if (mc !== 1'b1 || fv !== 1'b0) begin
        failures++;
        $display("FAIL R1: actual fv=%0b mc=%0b expected fv=0 mc=1", fv, mc);
      end
    end
    #1;
    rst_n = 1'b1;
    run = 1'b1;
    do_cycle(10, 3, 1'b0, 0, 0, "R2");
    do_cycle(10, 3, 1'b0, 0, 0, "R3");
    do_cycle(7, 7, 1'b0, 0, 0, "R3");
    do_cycle(5, 0, 1'b0, 0, 0, "R4");
    do_cycle(4, 9, 1'b0, 0, 0, "R5");
    do_cycle(0, 2, 1'b0, 0, 0, "R6");
    do_cycle(0, 0, 1'b0, 0, 0, "R6");
    do_cycle(1, 0, 1'b0, 0, 0, "R6");
    do_cycle(6, 2, 1'b1, 3, 5, "R7");
    do_cycle(3, 5, 1'b0, 0, 0, "R7");
    do_cycle(1023, 63, 1'b0, 0, 0, "R8");
    do_cycle(2, 1, 1'b0, 0, 0, "R2");
    run = 1'b0;
    if (sb.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", sb.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule